// File: doc/BRIEF.md
# Intra-Warp Co-Issue Set Allocator

After a warp's primary instruction has claimed part of a partitioned SIMD datapath, some SIMD sets are often left idle. This block looks at the same warp's secondary instruction-buffer half, which holds up to two instructions belonging to another divergent split. It decides which of those instructions can ride along in the idle sets. Each slot is examined in turn. Stale slots, whose split has died or moved on, flush the whole half. Slots on another functional-unit type, or slots that need more sets than remain, are passed over. Slots that fit receive a contiguous range of sets, starting at the running next-free index.

All decisions for one evaluation come from a single combinational pass over the slots. They are captured in an output register, so they appear one clock after the inputs are presented. Grants, slot-free commands and the flush command are plain level signals that the surrounding issue logic consumes in that cycle. There is no back-pressure, because the block holds no queued data.

Top module: `coissue_set_alloc`

## Requirements
- R1: No grant, slot-free or flush is produced unless all of the following hold: partitioning is enabled, a primary instruction is present, the available set count is non-zero, and the primary unit type is neither none (0) nor memory (7).
- R2: Slot 0 is examined before slot 1. An invalid slot is passed over. Examination ends once the remaining available set count is zero.
- R3: When an examined slot's split is reported invalid, the flush-half output is raised, that slot gets no grant, and no later slot is examined.
- R4: When an examined slot's split PC differs from the slot's instruction PC, the flush-half output is raised, that slot gets no grant, and no later slot is examined.
- R5: Each slot's unit type is decoded from its 4-bit op class as follows. Class 0 or 11 (plain ALU) maps to INT (2) when integer units exist and to SP (1) otherwise. Class 1 maps to SP. Class 2 maps to DP (3). Classes 3 and 4 map to SFU (4). Class 5 maps to TENSOR (5). Classes 6 to 10 map to MEM (7). Classes 12 and above map to SPECIALIZED (6). A slot whose type differs from the primary type is passed over without a flush.
- R6: A slot needs ceil(popcount(mask) / 2^set_width_lg) sets. A slot that needs more sets than remain is passed over.
- R7: On a grant, the slot's start set equals the running next-free index, and its set count equals its need. Its free bit is raised and its split id is reported. The running available count decreases by the need, and the next-free index increases by the need.
- R8: When a granted slot's split is reported dead after the grant, the flush-half output is raised and no later slot is examined.
- R9: All outputs reflect the inputs of the previous clock edge. During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_en_i | input | 1 | SIMD partitioning enabled |
| primary_valid_i | input | 1 | A primary composite instruction was issued |
| primary_fu_i | input | 3 | Primary unit type (0 none, 1 SP, 2 INT, 3 DP, 4 SFU, 5 TENSOR, 6 SPECIALIZED, 7 MEM) |
| int_units_i | input | 1 | Integer units exist |
| avail_sets_i | input | CNT_W | Free SIMD sets left by the primary |
| next_free_i | input | CNT_W | Index of the first free set |
| set_width_lg_i | input | LG_W | log2 of lanes per set |
| slot_valid_i | input | NUM_SLOTS | Secondary slot holds an instruction |
| slot_op_i | input | NUM_SLOTS*OP_W | Op class per slot |
| slot_pc_i | input | NUM_SLOTS*PC_W | Instruction PC per slot |
| slot_split_i | input | NUM_SLOTS*SID_W | Split id per slot |
| slot_mask_i | input | NUM_SLOTS*MASK_W | Split lane mask per slot |
| split_valid_i | input | NUM_SLOTS | Divergence-table lookup: split still valid |
| split_pc_i | input | NUM_SLOTS*PC_W | Divergence-table lookup: split's current PC |
| split_alive_i | input | NUM_SLOTS | Split still valid after the grant's update |
| grant_o | output | NUM_SLOTS | Slot co-issued |
| grant_start_o | output | NUM_SLOTS*CNT_W | First set of each grant |
| grant_sets_o | output | NUM_SLOTS*CNT_W | Set count of each grant |
| grant_split_o | output | NUM_SLOTS*SID_W | Split id of each grant |
| free_slot_o | output | NUM_SLOTS | Free this slot directly |
| flush_half_o | output | 1 | Flush the secondary half |
| avail_left_o | output | CNT_W | Sets still free after this pass |
| next_free_o | output | CNT_W | Next free set after this pass |

## Verification
The bench builds the block with its defaults: 32-lane masks, eight sets, and two secondary slots. With eight sets, a full 32-lane split at width 8 needs four sets, so it can be refused for lack of room while a smaller second slot still fits. Running the width exponent at both 3 and 2 exercises rounding up on partial sets. With two chained slots, every stop condition can fire either on the first slot, suppressing the second, or on the second slot after a grant.

// File: rtl/coissue_pkg.sv
package coissue_pkg;
  typedef enum logic [2:0] {
    FU_NONE   = 3'd0,
    FU_SP     = 3'd1,
    FU_INT    = 3'd2,
    FU_DP     = 3'd3,
    FU_SFU    = 3'd4,
    FU_TENSOR = 3'd5,
    FU_SPEC   = 3'd6,
    FU_MEM    = 3'd7
  } fu_kind_e;

  localparam int unsigned OPC_ALU      = 0;
  localparam int unsigned OPC_SP       = 1;
  localparam int unsigned OPC_DP       = 2;
  localparam int unsigned OPC_SFU      = 3;
  localparam int unsigned OPC_ALU_SFU  = 4;
  localparam int unsigned OPC_TENSOR   = 5;
  localparam int unsigned OPC_MEM_LO   = 6;
  localparam int unsigned OPC_MEM_HI   = 10;
  localparam int unsigned OPC_SPEC_LO  = 12;
endpackage

// File: rtl/alloc_fu_decode.sv
module alloc_fu_decode
  import coissue_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            int_units_i,
  output fu_kind_e        fu_o
);
  int unsigned opv;
  always_comb begin
    opv = int'(op_i);
    if (opv >= OPC_SPEC_LO)                            fu_o = FU_SPEC;
    else if (opv >= OPC_MEM_LO && opv <= OPC_MEM_HI)   fu_o = FU_MEM;
    else if (opv == OPC_SP)                            fu_o = FU_SP;
    else if (opv == OPC_DP)                            fu_o = FU_DP;
    else if (opv == OPC_SFU || opv == OPC_ALU_SFU)     fu_o = FU_SFU;
    else if (opv == OPC_TENSOR)                        fu_o = FU_TENSOR;
    else                                               fu_o = int_units_i ? FU_INT : FU_SP;
  end
endmodule

// File: rtl/alloc_set_need.sv
module alloc_set_need #(
  parameter int MASK_W = 32,
  parameter int LG_W   = 3,
  localparam int NEED_W = $clog2(MASK_W + 1)
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic [LG_W-1:0]   lg_i,
  output logic [NEED_W-1:0] need_o
);
  int unsigned pop;
  int unsigned rounded;
  always_comb begin
    pop = 0;
    for (int i = 0; i < MASK_W; i++) pop = pop + {31'd0, mask_i[i]};
    rounded = (pop + (32'd1 << lg_i) - 32'd1) >> lg_i;
    need_o  = NEED_W'(rounded);
  end
endmodule

// File: rtl/alloc_slot_stage.sv
module alloc_slot_stage
  import coissue_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int NEED_W = 6,
  parameter int PC_W   = 16,
  localparam int ARW   = ((NEED_W > CNT_W) ? NEED_W : CNT_W) + 1
) (
  input  logic              run_i,
  input  logic [CNT_W-1:0]  avail_i,
  input  logic [CNT_W-1:0]  next_i,
  input  logic              slot_valid_i,
  input  logic [PC_W-1:0]   slot_pc_i,
  input  logic              split_valid_i,
  input  logic [PC_W-1:0]   split_pc_i,
  input  logic              alive_i,
  input  fu_kind_e          fu_i,
  input  fu_kind_e          primary_fu_i,
  input  logic [NEED_W-1:0] need_i,
  output logic              run_o,
  output logic [CNT_W-1:0]  avail_o,
  output logic [CNT_W-1:0]  next_o,
  output logic              grant_o,
  output logic [CNT_W-1:0]  start_o,
  output logic [CNT_W-1:0]  sets_o,
  output logic              flush_o
);
  logic examine, stale, fits;
  always_comb begin
    examine = run_i && (avail_i != '0) && slot_valid_i;
    stale   = !split_valid_i || (split_pc_i != slot_pc_i);
    fits    = (fu_i == primary_fu_i) && (ARW'(need_i) <= ARW'(avail_i));
    run_o   = run_i;
    avail_o = avail_i;
    next_o  = next_i;
    grant_o = 1'b0;
    start_o = '0;
    sets_o  = '0;
    flush_o = 1'b0;
    if (examine) begin
      if (stale) begin
        flush_o = 1'b1;
        run_o   = 1'b0;
      end else if (fits) begin
        grant_o = 1'b1;
        start_o = next_i;
        sets_o  = CNT_W'(need_i);
        avail_o = avail_i - CNT_W'(need_i);
        next_o  = next_i + CNT_W'(need_i);
        if (!alive_i) begin
          flush_o = 1'b1;
          run_o   = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/coissue_set_alloc.sv
module coissue_set_alloc
  import coissue_pkg::*;
#(
  parameter int MASK_W    = 32,
  parameter int MAX_SETS  = 8,
  parameter int PC_W      = 16,
  parameter int SID_W     = 5,
  parameter int OP_W      = 4,
  parameter int LG_W      = 3,
  parameter int NUM_SLOTS = 2,
  localparam int CNT_W    = $clog2(MAX_SETS + 1),
  localparam int NEED_W   = $clog2(MASK_W + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         part_en_i,
  input  logic                         primary_valid_i,
  input  logic [2:0]                   primary_fu_i,
  input  logic                         int_units_i,
  input  logic [CNT_W-1:0]             avail_sets_i,
  input  logic [CNT_W-1:0]             next_free_i,
  input  logic [LG_W-1:0]              set_width_lg_i,
  input  logic [NUM_SLOTS-1:0]         slot_valid_i,
  input  logic [NUM_SLOTS*OP_W-1:0]    slot_op_i,
  input  logic [NUM_SLOTS*PC_W-1:0]    slot_pc_i,
  input  logic [NUM_SLOTS*SID_W-1:0]   slot_split_i,
  input  logic [NUM_SLOTS*MASK_W-1:0]  slot_mask_i,
  input  logic [NUM_SLOTS-1:0]         split_valid_i,
  input  logic [NUM_SLOTS*PC_W-1:0]    split_pc_i,
  input  logic [NUM_SLOTS-1:0]         split_alive_i,
  output logic [NUM_SLOTS-1:0]         grant_o,
  output logic [NUM_SLOTS*CNT_W-1:0]   grant_start_o,
  output logic [NUM_SLOTS*CNT_W-1:0]   grant_sets_o,
  output logic [NUM_SLOTS*SID_W-1:0]   grant_split_o,
  output logic [NUM_SLOTS-1:0]         free_slot_o,
  output logic                         flush_half_o,
  output logic [CNT_W-1:0]             avail_left_o,
  output logic [CNT_W-1:0]             next_free_o
);
  fu_kind_e pfu;
  logic     enable_c;
  assign pfu      = fu_kind_e'(primary_fu_i);
  assign enable_c = part_en_i && primary_valid_i && (avail_sets_i != '0) &&
                    (pfu != FU_NONE) && (pfu != FU_MEM);

  logic [NUM_SLOTS:0]         run_c;
  logic [CNT_W-1:0]           avail_c [NUM_SLOTS+1];
  logic [CNT_W-1:0]           next_c  [NUM_SLOTS+1];
  logic [NUM_SLOTS-1:0]       grant_c, flush_c;
  logic [NUM_SLOTS*CNT_W-1:0] start_c, sets_c;
  logic [NUM_SLOTS*SID_W-1:0] split_c;

  assign run_c[0]   = enable_c;
  assign avail_c[0] = avail_sets_i;
  assign next_c[0]  = next_free_i;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    fu_kind_e          fu_k;
    logic [NEED_W-1:0] need_k;

    alloc_fu_decode #(.OP_W(OP_W)) u_dec (
      .op_i        (slot_op_i[k*OP_W +: OP_W]),
      .int_units_i (int_units_i),
      .fu_o        (fu_k)
    );

    alloc_set_need #(.MASK_W(MASK_W), .LG_W(LG_W)) u_need (
      .mask_i (slot_mask_i[k*MASK_W +: MASK_W]),
      .lg_i   (set_width_lg_i),
      .need_o (need_k)
    );

    alloc_slot_stage #(.CNT_W(CNT_W), .NEED_W(NEED_W), .PC_W(PC_W)) u_stage (
      .run_i         (run_c[k]),
      .avail_i       (avail_c[k]),
      .next_i        (next_c[k]),
      .slot_valid_i  (slot_valid_i[k]),
      .slot_pc_i     (slot_pc_i[k*PC_W +: PC_W]),
      .split_valid_i (split_valid_i[k]),
      .split_pc_i    (split_pc_i[k*PC_W +: PC_W]),
      .alive_i       (split_alive_i[k]),
      .fu_i          (fu_k),
      .primary_fu_i  (pfu),
      .need_i        (need_k),
      .run_o         (run_c[k+1]),
      .avail_o       (avail_c[k+1]),
      .next_o        (next_c[k+1]),
      .grant_o       (grant_c[k]),
      .start_o       (start_c[k*CNT_W +: CNT_W]),
      .sets_o        (sets_c[k*CNT_W +: CNT_W]),
      .flush_o       (flush_c[k])
    );

    assign split_c[k*SID_W +: SID_W] =
      grant_c[k] ? slot_split_i[k*SID_W +: SID_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_o       <= '0;
      grant_start_o <= '0;
      grant_sets_o  <= '0;
      grant_split_o <= '0;
      free_slot_o   <= '0;
      flush_half_o  <= 1'b0;
      avail_left_o  <= '0;
      next_free_o   <= '0;
    end else begin
      grant_o       <= grant_c;
      grant_start_o <= start_c;
      grant_sets_o  <= sets_c;
      grant_split_o <= split_c;
      free_slot_o   <= grant_c;
      flush_half_o  <= |flush_c;
      avail_left_o  <= avail_c[NUM_SLOTS];
      next_free_o   <= next_c[NUM_SLOTS];
    end
  end

  // Sum of the set counts granted in the registered result.
  logic [CNT_W:0] granted_sum;
  always_comb begin
    granted_sum = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (grant_o[k]) granted_sum = granted_sum + (CNT_W+1)'(grant_sets_o[k*CNT_W +: CNT_W]);
  end

  a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_c |=> (grant_o == '0) && !flush_half_o && (free_slot_o == '0));

  a_r2_zero_budget_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_sets_i == '0) |=> (grant_o == '0));

  a_r3_dead_first_slot_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    enable_c && slot_valid_i[0] && !split_valid_i[0] |=> flush_half_o && (grant_o == '0));

  a_r7_budget_conserved: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((CNT_W+1)'(avail_left_o) + granted_sum) == (CNT_W+1)'($past(avail_sets_i)));

  for (genvar k = 1; k < NUM_SLOTS; k++) begin : g_pack_chk
    a_r7_grants_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[k] && grant_o[k-1] |->
        grant_start_o[k*CNT_W +: CNT_W] ==
        grant_start_o[(k-1)*CNT_W +: CNT_W] + grant_sets_o[(k-1)*CNT_W +: CNT_W]);
  end
endmodule

// File: tb/coissue_set_alloc_tb.sv
module coissue_set_alloc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        part_en, prim_v, int_units;
  logic [2:0]  prim_fu;
  logic [3:0]  avail, nxt;
  logic [2:0]  lg;
  logic [1:0]  sv, spv, alive;
  logic [7:0]  ops;
  logic [31:0] spc, slpc;
  logic [9:0]  sids;
  logic [63:0] masks;
  logic [1:0]  g, fr;
  logic [7:0]  gst, gsets;
  logic [9:0]  gsid;
  logic        fl;
  logic [3:0]  al, nfo;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coissue_set_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .part_en_i(part_en), .primary_valid_i(prim_v),
    .primary_fu_i(prim_fu), .int_units_i(int_units), .avail_sets_i(avail),
    .next_free_i(nxt), .set_width_lg_i(lg), .slot_valid_i(sv), .slot_op_i(ops),
    .slot_pc_i(slpc), .slot_split_i(sids), .slot_mask_i(masks),
    .split_valid_i(spv), .split_pc_i(spc), .split_alive_i(alive),
    .grant_o(g), .grant_start_o(gst), .grant_sets_o(gsets), .grant_split_o(gsid),
    .free_slot_o(fr), .flush_half_o(fl), .avail_left_o(al), .next_free_o(nfo)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        en, prim;
    logic [2:0]  pfu;
    logic        intu;
    logic [3:0]  av, nf;
    logic [2:0]  lgw;
    logic [1:0]  sv;
    logic [3:0]  op0, op1;
    logic [31:0] m0, m1;
    logic [1:0]  spv, mis, alive;
    logic [1:0]  eg;
    logic [3:0]  est0, en0, est1, en1;
    logic        efl;
    logic [3:0]  eal, enf;
  } vec_t;

  // Slot 0 is bit 0 of every 2-bit field. Unit codes: SP 1, INT 2, SFU 4, MEM 7.
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R2 R7: both slots fit, packed from next-free index 2
    '{4'd2,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFFFF,2'b11,2'b00,2'b11, 2'b11,4'd2,4'd1,4'd3,4'd2, 0,4'd1,4'd5},
    // R2: slot 0 takes the last two sets, slot 1 not examined
    '{4'd2,1,1,3'd1,1,4'd2,4'd0,3'd3,2'b11,4'd1,4'd1,32'h1FF,32'hF,2'b11,2'b00,2'b11, 2'b01,4'd0,4'd2,4'd0,4'd0, 0,4'd0,4'd2},
    // R3: slot 0 split invalid
    '{4'd3,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFF,2'b10,2'b00,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 1,4'd4,4'd2},
    // R4: slot 0 PC mismatch
    '{4'd4,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFF,2'b11,2'b01,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 1,4'd4,4'd2},
    // R5: slot 0 is DP under an SP primary, skipped without flush
    '{4'd5,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd2,4'd1,32'hFF,32'hFF,2'b11,2'b00,2'b11, 2'b10,4'd0,4'd0,4'd2,4'd1, 0,4'd3,4'd3},
    // R6: slot 0 needs 4 of 3 sets, skipped; slot 1 fits
    '{4'd6,1,1,3'd1,1,4'd3,4'd0,3'd3,2'b11,4'd1,4'd1,32'hFFFFFFFF,32'hFF,2'b11,2'b00,2'b11, 2'b10,4'd0,4'd0,4'd0,4'd1, 0,4'd2,4'd1},
    // R8: slot 0 split dies after its grant
    '{4'd8,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFF,2'b11,2'b00,2'b10, 2'b01,4'd2,4'd1,4'd0,4'd0, 1,4'd3,4'd3},
    // R6: width 4, 3 lanes -> 1 set, 5 lanes -> 2 sets
    '{4'd6,1,1,3'd1,1,4'd3,4'd0,3'd2,2'b11,4'd1,4'd1,32'h7,32'h1F,2'b11,2'b00,2'b11, 2'b11,4'd0,4'd1,4'd1,4'd2, 0,4'd0,4'd3},
    // R1: partitioning off
    '{4'd1,0,1,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFFFF,2'b11,2'b00,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 0,4'd4,4'd2},
    // R1: primary on memory unit
    '{4'd1,1,1,3'd7,1,4'd4,4'd2,3'd3,2'b11,4'd6,4'd6,32'hFF,32'hFF,2'b11,2'b00,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 0,4'd4,4'd2},
    // R1: no free sets
    '{4'd1,1,1,3'd1,1,4'd0,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFF,2'b11,2'b00,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 0,4'd0,4'd2},
    // R5: plain ALU -> INT matches; SP class on slot 1 skipped
    '{4'd5,1,1,3'd2,1,4'd4,4'd2,3'd3,2'b11,4'd0,4'd1,32'hFF,32'hFF,2'b11,2'b00,2'b11, 2'b01,4'd2,4'd1,4'd0,4'd0, 0,4'd3,4'd3},
    // R3: slot 0 empty, slot 1 split invalid
    '{4'd3,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b10,4'd1,4'd1,32'hFF,32'hFF,2'b01,2'b00,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 1,4'd4,4'd2},
    // R4: slot 0 granted, slot 1 PC stale
    '{4'd4,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFF,2'b11,2'b10,2'b11, 2'b01,4'd2,4'd1,4'd0,4'd0, 1,4'd3,4'd3},
    // R5: ALU_SFU class under SFU primary; specialized slot 1 skipped
    '{4'd5,1,1,3'd4,1,4'd4,4'd2,3'd3,2'b11,4'd4,4'd12,32'hFF,32'hFF,2'b11,2'b00,2'b11, 2'b01,4'd2,4'd1,4'd0,4'd0, 0,4'd3,4'd3},
    // R1: no primary instruction
    '{4'd1,1,0,3'd1,1,4'd4,4'd2,3'd3,2'b11,4'd1,4'd1,32'hFF,32'hFF,2'b11,2'b00,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 0,4'd4,4'd2},
    // R2: both slots empty
    '{4'd2,1,1,3'd1,1,4'd4,4'd2,3'd3,2'b00,4'd1,4'd1,32'hFF,32'hFF,2'b11,2'b00,2'b11, 2'b00,4'd0,4'd0,4'd0,4'd0, 0,4'd4,4'd2}
  };

  task automatic apply(input vec_t v);
    part_en = v.en; prim_v = v.prim; prim_fu = v.pfu; int_units = v.intu;
    avail = v.av; nxt = v.nf; lg = v.lgw; sv = v.sv;
    ops = {v.op1, v.op0}; masks = {v.m1, v.m0};
    spv = v.spv; alive = v.alive;
    slpc = {16'h0104, 16'h0100};
    spc  = {16'h0104 + 16'(v.mis[1]), 16'h0100 + 16'(v.mis[0])};
    sids = {5'd9, 5'd3};
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] outs();
    return {g, gst, gsets, gsid, fr, fl, al, nfo};
  endfunction

  function automatic logic [63:0] expect_of(input vec_t v);
    logic [9:0] es;
    es = {v.eg[1] ? 5'd9 : 5'd0, v.eg[0] ? 5'd3 : 5'd0};
    return {v.eg, v.est1, v.est0, v.en1, v.en0, es, v.eg, v.efl, v.eal, v.enf};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R9: reset holds outputs at zero even with live inputs
    check("R9 reset state", outs(), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), outs(), expect_of(VECS[i]));
    end

    // R9 latency: new inputs do not show before the next edge
    apply(VECS[0]);
    @(negedge clk);
    apply(VECS[8]);
    #1;
    check("R9 output held until edge", outs(), expect_of(VECS[0]));
    @(negedge clk);
    check("R9 output after edge", outs(), expect_of(VECS[8]));

    // R7: split ids reported for both grants
    apply(VECS[0]);
    @(negedge clk);
    check("R7 split ids", {54'd0, gsid}, {54'd0, 5'd9, 5'd3});

    // R9: reset in mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset mid-stream", outs(), 64'd0);
    rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule